// File: doc/BRIEF.md
# Buffered Up-Count PWM Generator

This block produces a pulse-width-modulated waveform from a 16-bit counter that climbs from zero to an active period value and then starts again at zero. A prescaler slows the counting so that the counter advances once every (prescale + 1) clock cycles. The programmed period and compare values are held in shadow form at the inputs. They are copied into active buffers when counting is started and again each time the counter wraps at the period point, so a new setting never cuts a cycle short.

A two-state controller (`ST_IDLE`, `ST_RUN`) governs counting. The transitions are: `ST_IDLE -> ST_RUN` on a start pulse, which zeroes the counter and loads both buffers. `ST_RUN -> ST_RUN` on a start pulse, which restarts the count and reloads the buffers. `ST_RUN -> ST_IDLE` on a stop pulse. `ST_RUN -> ST_IDLE` at the period point when one-shot mode is selected. The waveform is high while the counter is below the active compare value. It can be inverted and forced inactive with an output enable.

Three sticky write-one-to-clear flags record the period point, the compare-up point and the counter reaching 0xFFFF. A selectable event drives one trigger pulse per target, and each target has a sticky occurred flag of its own.

Top module: `upcnt_pwm`

## Requirements
- R1: After reset the block is in `ST_IDLE` with the counter, both active buffers, all flags, all trigger pulses and all occurred flags at zero.
- R2: A start pulse (which takes priority over stop and clear) sets running, zeroes the counter and prescaler, and copies `period_i` and `cmp_i` into the active buffers.
- R3: While running, the counter advances once every `prescale_i + 1` clock cycles, counted from the start pulse; a prescale of 0 advances it on every cycle.
- R4: In auto-reload mode (`oneshot_i` = 0) the counter steps from the active period back to 0, and at that wrap the active buffers take the current `period_i` and `cmp_i`; input changes at other times do not alter the active buffers.
- R5: In one-shot mode (`oneshot_i` = 1) running clears in the cycle where the counter reaches the active period, and the counter then holds that value.
- R6: `period_flag_o` sets together with the counter step that lands on the active period and stays set until cleared through `flag_w1c_i[0]`; a set and a clear in the same cycle leave it set.
- R7: `cmp_flag_o` sets together with the counter step that lands on the active compare value, except when the active compare equals the active period. It is cleared through `flag_w1c_i[1]`.
- R8: `max_flag_o` sets when a counter step lands on 0xFFFF and is cleared through `flag_w1c_i[2]`.
- R9: A clear pulse (`clr_cnt_i`) without start or stop zeroes the counter and prescaler in the next cycle; a stop pulse takes priority over it.
- R10: `pwm_o` equals (counter < active compare) XOR `invert_i` while `out_en_i` is 1. With `out_en_i` at 0, `pwm_o` is 0 and `pwm_oe_o` is 0, meaning the pin is released.
- R11: `trig_sel_i` chooses the trigger event: 2'b00 period point, 2'b01 compare point, 2'b10 either, 2'b11 none. `trig_o[i]` pulses in the same cycle as the matching flag sets, and only when `trig_en_i[i]` is 1.
- R12: `trig_seen_o[i]` sets with each `trig_o[i]` pulse and holds until cleared through `seen_w1c_i[i]`; a set wins over a same-cycle clear.
- R13: A stop pulse while running returns to `ST_IDLE` with the counter and buffers held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start/restart pulse |
| stop_i | input | 1 | Stop pulse |
| clr_cnt_i | input | 1 | Counter clear command pulse |
| oneshot_i | input | 1 | 1 = one-shot, 0 = auto-reload |
| prescale_i | input | 8 | Clock divide value minus one |
| period_i | input | 16 | Programmed (shadow) period |
| cmp_i | input | 16 | Programmed (shadow) compare |
| invert_i | input | 1 | Output polarity inversion |
| out_en_i | input | 1 | Output drive enable |
| trig_sel_i | input | 2 | Trigger event select |
| trig_en_i | input | 3 | Per-target trigger enable |
| flag_w1c_i | input | 3 | Clear strobes: bit0 period, bit1 compare, bit2 max |
| seen_w1c_i | input | 3 | Clear strobes for trigger occurred flags |
| running_o | output | 1 | High in `ST_RUN` |
| cnt_o | output | 16 | Counter value |
| period_act_o | output | 16 | Active period buffer |
| cmp_act_o | output | 16 | Active compare buffer |
| pwm_o | output | 1 | PWM waveform |
| pwm_oe_o | output | 1 | Pin drive enable |
| period_flag_o | output | 1 | Sticky period-point flag |
| cmp_flag_o | output | 1 | Sticky compare-up flag |
| max_flag_o | output | 1 | Sticky counter-at-0xFFFF flag |
| trig_o | output | 3 | Trigger pulses per target |
| trig_seen_o | output | 3 | Sticky trigger occurred flags |

## Verification
Seeded random runs vary the prescale (0 to 3), short periods including 0, and compare values below, equal to and above the period. These runs separate a counter that wraps one step early or late from a correct one, and they expose a compare flag that leaks when compare equals period. The random runs also change the shadow values in the middle of a run and mix in start, stop, clear and clear-strobe pulses at random. Together these tell a reload at the wrap apart from an immediate load, and show the priority between commands and between set and clear of the flags. Directed cases fix the prescale timing from the start pulse, a one-shot stop, a reserved trigger select, and a full 0xFFFF period that reaches the maximum flag.

// File: rtl/upcnt_pwm_pkg.sv
package upcnt_pwm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        TS_PERIOD = 2'b00,
        TS_CMP    = 2'b01,
        TS_EITHER = 2'b10,
        TS_NONE   = 2'b11
    } trig_src_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] psc_q;

    assign tick = run && (psc_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_q <= '0;
        end else if (restart || !run || tick) begin
            psc_q <= '0;
        end else begin
            psc_q <= psc_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import upcnt_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic             clr,
    input  logic             oneshot,
    input  logic             tick,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] cmp_in,
    output logic             running,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cmp_act,
    output logic             per_ev,
    output logic             cmp_ev,
    output logic             max_ev
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    run_state_e       state_q, state_d;
    logic             wrap, adv;
    logic [CNT_W-1:0] cnt_nx, per_nx, cmp_nx;

    always_comb begin
        wrap   = (cnt == per_act);
        cnt_nx = wrap ? '0 : cnt + 1'b1;
        per_nx = wrap ? period_in : per_act;
        cmp_nx = wrap ? cmp_in : cmp_act;
        adv    = (state_q == ST_RUN) && tick && !start && !stop && !clr;
        per_ev = adv && (cnt_nx == per_nx);
        cmp_ev = adv && (cnt_nx == cmp_nx) && (cmp_nx != per_nx);
        max_ev = adv && (cnt_nx == CNT_MAX);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (start)                    state_d = ST_RUN;
                else if (stop)                state_d = ST_IDLE;
                else if (per_ev && oneshot)   state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            per_act <= '0;
            cmp_act <= '0;
        end else if (start) begin
            cnt     <= '0;
            per_act <= period_in;
            cmp_act <= cmp_in;
        end else if (stop) begin
            cnt     <= cnt;
        end else if (clr) begin
            cnt     <= '0;
        end else if (adv) begin
            cnt     <= cnt_nx;
            per_act <= per_nx;
            cmp_act <= cmp_nx;
        end
    end

    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/pwm_event_flags.sv
module pwm_event_flags
    import upcnt_pwm_pkg::*;
#(
    parameter int N_TRIG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              per_ev,
    input  logic              cmp_ev,
    input  logic              max_ev,
    input  logic [1:0]        trig_sel,
    input  logic [N_TRIG-1:0] trig_en,
    input  logic [2:0]        flag_w1c,
    input  logic [N_TRIG-1:0] seen_w1c,
    output logic              period_flag,
    output logic              cmp_flag,
    output logic              max_flag,
    output logic [N_TRIG-1:0] trig,
    output logic [N_TRIG-1:0] trig_seen
);
    logic trig_ev;

    always_comb begin
        unique case (trig_src_e'(trig_sel))
            TS_PERIOD: trig_ev = per_ev;
            TS_CMP:    trig_ev = cmp_ev;
            TS_EITHER: trig_ev = per_ev || cmp_ev;
            TS_NONE:   trig_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_flag <= 1'b0;
            cmp_flag    <= 1'b0;
            max_flag    <= 1'b0;
        end else begin
            period_flag <= per_ev || (period_flag && !flag_w1c[0]);
            cmp_flag    <= cmp_ev || (cmp_flag && !flag_w1c[1]);
            max_flag    <= max_ev || (max_flag && !flag_w1c[2]);
        end
    end

    for (genvar g = 0; g < N_TRIG; g++) begin : g_target
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trig[g]      <= 1'b0;
                trig_seen[g] <= 1'b0;
            end else begin
                trig[g]      <= trig_ev && trig_en[g];
                trig_seen[g] <= (trig_ev && trig_en[g]) || (trig_seen[g] && !seen_w1c[g]);
            end
        end
    end
endmodule

// File: rtl/upcnt_pwm.sv
module upcnt_pwm #(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 8,
    parameter int N_TRIG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              clr_cnt_i,
    input  logic              oneshot_i,
    input  logic [PSC_W-1:0]  prescale_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [CNT_W-1:0]  cmp_i,
    input  logic              invert_i,
    input  logic              out_en_i,
    input  logic [1:0]        trig_sel_i,
    input  logic [N_TRIG-1:0] trig_en_i,
    input  logic [2:0]        flag_w1c_i,
    input  logic [N_TRIG-1:0] seen_w1c_i,
    output logic              running_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  period_act_o,
    output logic [CNT_W-1:0]  cmp_act_o,
    output logic              pwm_o,
    output logic              pwm_oe_o,
    output logic              period_flag_o,
    output logic              cmp_flag_o,
    output logic              max_flag_o,
    output logic [N_TRIG-1:0] trig_o,
    output logic [N_TRIG-1:0] trig_seen_o
);
    logic tick, per_ev, cmp_ev, max_ev, raw_wave;

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running_o),
        .restart (start_i || clr_cnt_i),
        .div     (prescale_i),
        .tick    (tick)
    );

    pwm_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .stop      (stop_i),
        .clr       (clr_cnt_i),
        .oneshot   (oneshot_i),
        .tick      (tick),
        .period_in (period_i),
        .cmp_in    (cmp_i),
        .running   (running_o),
        .cnt       (cnt_o),
        .per_act   (period_act_o),
        .cmp_act   (cmp_act_o),
        .per_ev    (per_ev),
        .cmp_ev    (cmp_ev),
        .max_ev    (max_ev)
    );

    pwm_event_flags #(.N_TRIG(N_TRIG)) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .per_ev      (per_ev),
        .cmp_ev      (cmp_ev),
        .max_ev      (max_ev),
        .trig_sel    (trig_sel_i),
        .trig_en     (trig_en_i),
        .flag_w1c    (flag_w1c_i),
        .seen_w1c    (seen_w1c_i),
        .period_flag (period_flag_o),
        .cmp_flag    (cmp_flag_o),
        .max_flag    (max_flag_o),
        .trig        (trig_o),
        .trig_seen   (trig_seen_o)
    );

    assign raw_wave = (cnt_o < cmp_act_o);
    assign pwm_oe_o = out_en_i;
    assign pwm_o    = out_en_i && (raw_wave ^ invert_i);
endmodule

// File: rtl/upcnt_pwm_chk.sv
module upcnt_pwm_chk #(
    parameter int CNT_W  = 16,
    parameter int N_TRIG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              clr_cnt_i,
    input logic              out_en_i,
    input logic              running_o,
    input logic [CNT_W-1:0]  cnt_o,
    input logic [CNT_W-1:0]  period_act_o,
    input logic [CNT_W-1:0]  cmp_act_o,
    input logic              pwm_o,
    input logic              period_flag_o,
    input logic              cmp_flag_o,
    input logic              max_flag_o,
    input logic [N_TRIG-1:0] trig_o,
    input logic [N_TRIG-1:0] trig_seen_o
);
    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |-> (cnt_o <= period_act_o));

    // R5
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running_o) && !$past(stop_i)) |-> (cnt_o == period_act_o));

    // R6
    period_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(period_flag_o) |-> (cnt_o == period_act_o));

    // R7
    cmp_flag_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp_flag_o) |-> (cmp_act_o != period_act_o) && (cnt_o == cmp_act_o));

    // R8
    max_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(max_flag_o) |-> (cnt_o == {CNT_W{1'b1}}));

    // R9
    clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cnt_i && !stop_i) |=> (cnt_o == '0));

    // R10
    released_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> !pwm_o);

    for (genvar g = 0; g < N_TRIG; g++) begin : g_seen
        // R12
        trig_seen_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            trig_o[g] |-> trig_seen_o[g]);
    end
endmodule

bind upcnt_pwm upcnt_pwm_chk #(.CNT_W(CNT_W), .N_TRIG(N_TRIG)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_i        (stop_i),
    .clr_cnt_i     (clr_cnt_i),
    .out_en_i      (out_en_i),
    .running_o     (running_o),
    .cnt_o         (cnt_o),
    .period_act_o  (period_act_o),
    .cmp_act_o     (cmp_act_o),
    .pwm_o         (pwm_o),
    .period_flag_o (period_flag_o),
    .cmp_flag_o    (cmp_flag_o),
    .max_flag_o    (max_flag_o),
    .trig_o        (trig_o),
    .trig_seen_o   (trig_seen_o)
);

// File: tb/upcnt_pwm_tb_top.sv
`timescale 1ns/1ps
module upcnt_pwm_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, stop_i = 0, clr_cnt_i = 0, oneshot_i = 0;
    logic [7:0]  prescale_i = 0;
    logic [15:0] period_i = 0, cmp_i = 0;
    logic        invert_i = 0, out_en_i = 0;
    logic [1:0]  trig_sel_i = 0;
    logic [2:0]  trig_en_i = 0, flag_w1c_i = 0, seen_w1c_i = 0;
    logic        running_o, pwm_o, pwm_oe_o, period_flag_o, cmp_flag_o, max_flag_o;
    logic [15:0] cnt_o, period_act_o, cmp_act_o;
    logic [2:0]  trig_o, trig_seen_o;

    int n_chk = 0;
    int n_fail = 0;

    // reference state computed from the requirements
    logic        m_run, n_run;
    logic [7:0]  m_psc, n_psc;
    logic [15:0] m_cnt, n_cnt, m_per, n_per, m_cmp, n_cmp;
    logic        m_pf, n_pf, m_cf, n_cf, m_mf, n_mf;
    logic [2:0]  m_trig, n_trig, m_seen, n_seen;

    always #2.5 clk = ~clk;

    upcnt_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .clr_cnt_i(clr_cnt_i), .oneshot_i(oneshot_i), .prescale_i(prescale_i),
        .period_i(period_i), .cmp_i(cmp_i), .invert_i(invert_i), .out_en_i(out_en_i),
        .trig_sel_i(trig_sel_i), .trig_en_i(trig_en_i), .flag_w1c_i(flag_w1c_i),
        .seen_w1c_i(seen_w1c_i), .running_o(running_o), .cnt_o(cnt_o),
        .period_act_o(period_act_o), .cmp_act_o(cmp_act_o), .pwm_o(pwm_o),
        .pwm_oe_o(pwm_oe_o), .period_flag_o(period_flag_o), .cmp_flag_o(cmp_flag_o),
        .max_flag_o(max_flag_o), .trig_o(trig_o), .trig_seen_o(trig_seen_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_pwm(input logic [15:0] c, input logic [15:0] k, input logic inv, input logic oe);
        return oe && ((c < k) ^ inv);
    endfunction

    function automatic logic trig_event(input logic [1:0] sel, input logic pe, input logic ce);
        case (sel)
            2'b00:   return pe;
            2'b01:   return ce;
            2'b10:   return pe || ce;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_run = 0; m_psc = 0; m_cnt = 0; m_per = 0; m_cmp = 0;
        m_pf = 0; m_cf = 0; m_mf = 0; m_trig = 0; m_seen = 0;
    endtask

    task automatic model_next();
        logic tick, pe, ce, me, ev;
        tick = m_run && (m_psc == prescale_i);
        n_psc = (start_i || clr_cnt_i) ? 8'd0 : (m_run ? (tick ? 8'd0 : m_psc + 8'd1) : 8'd0);
        pe = 0; ce = 0; me = 0;
        n_run = m_run; n_cnt = m_cnt; n_per = m_per; n_cmp = m_cmp;
        if (start_i) begin
            n_run = 1; n_cnt = 0; n_per = period_i; n_cmp = cmp_i;
        end else if (stop_i) begin
            n_run = 0;
        end else if (clr_cnt_i) begin
            n_cnt = 0;
        end else if (tick) begin
            if (m_cnt == m_per) begin
                n_cnt = 0; n_per = period_i; n_cmp = cmp_i;
            end else begin
                n_cnt = m_cnt + 16'd1;
            end
            pe = (n_cnt == n_per);
            ce = (n_cnt == n_cmp) && (n_cmp != n_per);
            me = (n_cnt == 16'hFFFF);
            if (pe && oneshot_i) n_run = 0;
        end
        n_pf = pe || (m_pf && !flag_w1c_i[0]);
        n_cf = ce || (m_cf && !flag_w1c_i[1]);
        n_mf = me || (m_mf && !flag_w1c_i[2]);
        ev = trig_event(trig_sel_i, pe, ce);
        n_trig = {3{ev}} & trig_en_i;
        n_seen = n_trig | (m_seen & ~seen_w1c_i);
    endtask

    task automatic compare_all();
        chk("R13", "running", running_o, m_run);
        chk("R4", "cnt", cnt_o, m_cnt);
        chk("R2", "period_act", period_act_o, m_per);
        chk("R2", "cmp_act", cmp_act_o, m_cmp);
        chk("R10", "pwm", pwm_o, exp_pwm(m_cnt, m_cmp, invert_i, out_en_i));
        chk("R10", "pwm_oe", pwm_oe_o, out_en_i);
        chk("R6", "period_flag", period_flag_o, m_pf);
        chk("R7", "cmp_flag", cmp_flag_o, m_cf);
        chk("R8", "max_flag", max_flag_o, m_mf);
        chk("R11", "trig", trig_o, m_trig);
        chk("R12", "trig_seen", trig_seen_o, m_seen);
    endtask

    task automatic step();
        model_next();
        @(posedge clk);
        m_run = n_run; m_psc = n_psc; m_cnt = n_cnt; m_per = n_per; m_cmp = n_cmp;
        m_pf = n_pf; m_cf = n_cf; m_mf = n_mf; m_trig = n_trig; m_seen = n_seen;
        @(negedge clk);
        compare_all();
        start_i = 0; stop_i = 0; clr_cnt_i = 0; flag_w1c_i = 0; seen_w1c_i = 0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(190000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0C1A);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "running", running_o, 0);
        chk("R1", "cnt", cnt_o, 0);
        chk("R1", "flags", {period_flag_o, cmp_flag_o, max_flag_o}, 0);
        chk("R1", "trig", {trig_o, trig_seen_o}, 0);
        chk("R1", "buffers", {period_act_o, cmp_act_o}, 0);

        // R3: prescale 2 -> first advance three cycles after start
        prescale_i = 2; period_i = 10; cmp_i = 4; out_en_i = 1; trig_sel_i = 2'b00; trig_en_i = 3'b101;
        start_i = 1; step();
        chk("R2", "cnt after start", cnt_o, 0);
        chk("R2", "period loaded", period_act_o, 10);
        step(); step();
        chk("R3", "cnt before div", cnt_o, 0);
        step();
        chk("R3", "cnt after div", cnt_o, 1);

        // R4: shadow change mid-run is deferred to the wrap
        period_i = 6; step();
        chk("R4", "period not yet loaded", period_act_o, 10);
        repeat (40) step();
        chk("R4", "period loaded at wrap", period_act_o, 6);

        // R9: clear command
        clr_cnt_i = 1; step();
        chk("R9", "cnt cleared", cnt_o, 0);

        // R13: stop holds
        repeat (5) step();
        stop_i = 1; step();
        chk("R13", "stopped", running_o, 0);
        repeat (4) step();

        // R5: one-shot with compare == period (R7 suppression)
        prescale_i = 0; period_i = 4; cmp_i = 4; oneshot_i = 1; flag_w1c_i = 3'b111; seen_w1c_i = 3'b111;
        start_i = 1; step();
        repeat (4) step();
        chk("R5", "stopped at period", running_o, 0);
        chk("R5", "cnt held", cnt_o, 4);
        chk("R7", "no cmp flag when equal", cmp_flag_o, 0);
        repeat (3) step();
        chk("R5", "cnt still held", cnt_o, 4);

        // R11: reserved select gives no triggers
        oneshot_i = 0; trig_sel_i = 2'b11; trig_en_i = 3'b111; seen_w1c_i = 3'b111; cmp_i = 2;
        start_i = 1; step();
        repeat (20) step();
        chk("R11", "reserved select", trig_seen_o, 0);

        // random phase
        for (int it = 0; it < 40; it++) begin
            prescale_i = 8'($urandom % 4);
            period_i   = 16'($urandom % 24);
            cmp_i      = (it % 5 == 0) ? period_i : 16'($urandom % 26);
            oneshot_i  = ($urandom % 4 == 0);
            invert_i   = 1'($urandom);
            out_en_i   = 1'($urandom);
            trig_sel_i = 2'($urandom);
            trig_en_i  = 3'($urandom);
            start_i = 1; step();
            for (int k = 0; k < 300; k++) begin
                int r;
                r = int'($urandom % 100);
                if (r < 2)       clr_cnt_i = 1;
                else if (r < 3)  stop_i = 1;
                else if (r < 6)  start_i = 1;
                else if (r < 11) begin flag_w1c_i = 3'($urandom); seen_w1c_i = 3'($urandom); end
                else if (r < 14) begin period_i = 16'($urandom % 24); cmp_i = 16'($urandom % 26); end
                step();
            end
        end

        // R8: full-range period reaches 0xFFFF
        prescale_i = 0; period_i = 16'hFFFF; cmp_i = 16'h0010; oneshot_i = 0;
        flag_w1c_i = 3'b111; start_i = 1; step();
        for (int k = 0; k < 65535; k++) step();
        chk("R8", "cnt at max", cnt_o, 16'hFFFF);
        chk("R8", "max flag", max_flag_o, 1);
        step();
        chk("R4", "wrap after max", cnt_o, 0);
        flag_w1c_i = 3'b100; step();
        chk("R8", "max flag cleared", max_flag_o, 0);

        finish_run();
    end
endmodule